// File: doc/BRIEF.md
# Tone-Pair Steering and Guard-Time Qualifier

This block decides when a tone pair reported by a frequency detector becomes an accepted digit. The detector supplies a raw "valid pair present" flag and a 4-bit code. The block registers the flag as an early steering indication. That indication drops as soon as the raw flag drops for even one cycle. A second, slower stage then gives the digit its final qualification. This stage holds a steering state and a guard timer. The timer counts consecutive cycles in which the early indication disagrees with the steering state. Any cycle of agreement clears it.

When the early indication has been high for a programmable number of cycles (`present_cycles`), the steering state goes high. In that same step the code is copied into the output register and a one-cycle "digit received" pulse is raised. The steering state returns low only after the early indication has stayed low for a second programmable count (`absent_cycles`). Only after that return can another digit be accepted. A guard output shows whether the steering path is being held up, either by a present tone or by a digit that is still held.

Top module: `tonepair_qualifier`

## Requirements
- R1: While `rst_n` is low, and after it is released with `pair_valid` low, `early_flag`, `guard_out` and `digit_strobe` are 0 and `code_out` is 4'h0.
- R2: `early_flag` equals `pair_valid` as sampled at the previous rising clock edge. A single low cycle of `pair_valid` gives a single low cycle of `early_flag`.
- R3: Let edge 1 be the first rising edge that samples `pair_valid` high, with no digit held. If `pair_valid` stays high for N >= `present_cycles` consecutive edges, `digit_strobe` is high in the cycle after edge `present_cycles`+1. If N < `present_cycles`, no digit is accepted.
- R4: On acceptance, `code_out` takes the `pair_code` value sampled with the tone. It keeps that value unchanged until the next acceptance.
- R5: `digit_strobe` is high for exactly one clock cycle per accepted digit.
- R6: After an acceptance, no further digit is accepted until `pair_valid` has been low for at least `absent_cycles` consecutive edges. A shorter dropout followed by the tone again produces no second strobe.
- R7: `guard_out` is 1 whenever `early_flag` is 1 or a digit is held (accepted and not yet released). Once `pair_valid` has been low for at least `absent_cycles`+1 edges, `guard_out` is 0.
- R8: Any loss of `early_flag` before acceptance restarts the present timer. Two bursts of `present_cycles`-1 edges each, separated by a one-cycle dropout, are not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_valid | input | 1 | Raw valid-tone-pair flag from the detector |
| pair_code | input | 4 | Decoded code of the present tone pair |
| present_cycles | input | TIME_W | Cycles the tone must persist before acceptance |
| absent_cycles | input | TIME_W | Cycles of silence needed to release a held digit |
| early_flag | output | 1 | Early steering indication |
| guard_out | output | 1 | Guard-time output: tone present or digit held |
| code_out | output | 4 | Latched code of the last accepted digit |
| digit_strobe | output | 1 | One-cycle pulse on each acceptance |

## Verification
The bench probes the acceptance boundary with tones exactly `present_cycles` long and one cycle shorter. A timer off by one would accept the short tone or reject the exact one. It measures the cycle in which the strobe appears, so an extra or missing register stage shows up as a shifted pulse. Dropouts shorter than `absent_cycles` are inserted inside a held digit, and a design that releases too early would emit a duplicate digit that the scoreboard rejects. Split bursts check that the present timer restarts rather than accumulating across a dropout.

// File: rtl/tq_pkg.sv
package tq_pkg;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [1:0] {
    DIR_HOLD   = 2'd0,
    DIR_CHARGE = 2'd1,
    DIR_DRAIN  = 2'd2
  } steer_dir_e;
endpackage

// File: rtl/tq_sampler.sv
module tq_sampler #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [CODE_W-1:0] code_in,
  output logic              early_q,
  output logic [CODE_W-1:0] code_q
);
  logic              early_nxt;
  logic [CODE_W-1:0] code_nxt;

  always_comb begin
    early_nxt = valid_in;
    code_nxt  = valid_in ? code_in : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_q <= 1'b0;
      code_q  <= '0;
    end else begin
      early_q <= early_nxt;
      code_q  <= code_nxt;
    end
  end
endmodule

// File: rtl/tq_guard_timer.sv
module tq_guard_timer
  import tq_pkg::*;
#(
  parameter int unsigned TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              early,
  input  logic [TIME_W-1:0] t_present,
  input  logic [TIME_W-1:0] t_absent,
  output logic              steer,
  output logic              accept
);
  localparam int unsigned CMP_W = TIME_W + 1;

  steer_dir_e        dir;
  logic [TIME_W-1:0] cnt, cnt_nxt, limit;
  logic              steer_nxt, hit;
  logic [CMP_W-1:0]  cnt_inc;

  always_comb begin
    if (early && !steer)      dir = DIR_CHARGE;
    else if (!early && steer) dir = DIR_DRAIN;
    else                      dir = DIR_HOLD;

    limit   = (dir == DIR_CHARGE) ? t_present : t_absent;
    cnt_inc = {1'b0, cnt} + CMP_W'(1);
    hit     = (dir != DIR_HOLD) && (cnt_inc >= {1'b0, limit});

    cnt_nxt   = (dir == DIR_HOLD || hit) ? '0 : cnt_inc[TIME_W-1:0];
    steer_nxt = hit ? !steer : steer;
    accept    = hit && (dir == DIR_CHARGE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      steer <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      steer <= steer_nxt;
    end
  end

  // R8: timer is cleared whenever early and steering agree
  a_r8_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (early == steer) |=> (cnt == '0));

  // R6: steering can only fall after early has been low
  a_r6_release_needs_silence: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(steer) |-> !$past(early));
endmodule

// File: rtl/tq_code_latch.sv
module tq_code_latch #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_out,
  output logic              strobe
);
  logic [CODE_W-1:0] code_nxt;
  logic              strobe_nxt;

  always_comb begin
    code_nxt   = load ? code_in : code_out;
    strobe_nxt = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_out <= '0;
      strobe   <= 1'b0;
    end else begin
      code_out <= code_nxt;
      strobe   <= strobe_nxt;
    end
  end

  // R5: the received pulse lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  // R4: the latched code only moves together with the pulse
  a_r4_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> $stable(code_out));
endmodule

// File: rtl/tonepair_qualifier.sv
module tonepair_qualifier
  import tq_pkg::*;
#(
  parameter int unsigned TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_valid,
  input  logic [3:0]        pair_code,
  input  logic [TIME_W-1:0] present_cycles,
  input  logic [TIME_W-1:0] absent_cycles,
  output logic              early_flag,
  output logic              guard_out,
  output logic [3:0]        code_out,
  output logic              digit_strobe
);
  logic [CODE_W-1:0] code_q;
  logic              early_q, steer, accept;

  tq_sampler #(.CODE_W(CODE_W)) u_samp (
    .clk(clk), .rst_n(rst_n), .valid_in(pair_valid), .code_in(pair_code),
    .early_q(early_q), .code_q(code_q)
  );

  tq_guard_timer #(.TIME_W(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .early(early_q),
    .t_present(present_cycles), .t_absent(absent_cycles),
    .steer(steer), .accept(accept)
  );

  tq_code_latch #(.CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(accept), .code_in(code_q),
    .code_out(code_out), .strobe(digit_strobe)
  );

  assign early_flag = early_q;
  assign guard_out  = early_q | steer;

  // R3: a digit is only announced while a tone was present
  a_r3_strobe_after_tone: assert property (@(posedge clk) disable iff (!rst_n)
    digit_strobe |-> $past(early_q));

  // R7: guard stays up while the early flag is high
  a_r7_guard_covers_early: assert property (@(posedge clk) disable iff (!rst_n)
    early_flag |-> guard_out);
endmodule

// File: tb/sim_tonepair_qualifier.sv
module sim_tonepair_qualifier;
  localparam int CLK_PERIOD = 10;
  localparam int TP = 5;
  localparam int TA = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pair_valid;
  logic [3:0] pair_code;
  logic [7:0] present_cycles, absent_cycles;
  logic       early_flag, guard_out, digit_strobe;
  logic [3:0] code_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  int strobe_idx;
  logic [3:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tonepair_qualifier u0 (
    .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pair_code(pair_code),
    .present_cycles(present_cycles), .absent_cycles(absent_cycles),
    .early_flag(early_flag), .guard_out(guard_out),
    .code_out(code_out), .digit_strobe(digit_strobe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe must match the next expected code
  always @(negedge clk) begin
    if (rst_n && digit_strobe) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6: actual unexpected digit %0d expected none", code_out);
      end else begin
        check("R4 scoreboard code", int'(code_out), int'(exp_q.pop_front()));
      end
    end
  end

  // driver: tone of L edges; pushes expected digit when it qualifies
  task automatic tone(input logic [3:0] c, input int len, input bit accepted);
    if (accepted) exp_q.push_back(c);
    strobe_idx = 0;
    pair_valid = 1'b1;
    pair_code  = c;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (digit_strobe && strobe_idx == 0) strobe_idx = i;
    end
    pair_valid = 1'b0;
  endtask

  task automatic gap(input int len);
    pair_valid = 1'b0;
    for (int i = 0; i < len; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pair_valid = 1'b0;
    pair_code = 4'h0;
    present_cycles = 8'(TP);
    absent_cycles  = 8'(TA);
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 early", int'(early_flag), 0);
    check("R1 guard", int'(guard_out), 0);
    check("R1 strobe", int'(digit_strobe), 0);
    check("R1 code", int'(code_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 code after release", int'(code_out), 0);

    // R2: one-cycle lag and single-cycle dropout
    pair_valid = 1'b1; pair_code = 4'h7;
    #1 check("R2 before edge", int'(early_flag), 0);
    @(negedge clk);
    check("R2 after edge", int'(early_flag), 1);
    pair_valid = 1'b0;
    @(negedge clk);
    check("R2 dropout low", int'(early_flag), 0);
    gap(TA + 3);

    // R3: timing of the strobe, code captured (R4)
    tone(4'h3, TP + 3, 1);
    check("R3 strobe cycle", strobe_idx, TP + 1);
    check("R4 code held", int'(code_out), 3);
    gap(TA + 3);
    check("R7 guard released", int'(guard_out), 0);

    // R3 boundary: exactly TP accepted, TP-1 rejected
    tone(4'h9, TP, 1);
    gap(TA + 3);
    check("R4 boundary code", int'(code_out), 9);
    tone(4'hC, TP - 1, 0);
    gap(TA + 3);
    check("R3 short tone ignored", int'(code_out), 9);

    // R6 and R7: short dropout inside a held digit
    tone(4'h5, TP + 3, 1);
    gap(TA - 2);
    check("R7 guard held in dropout", int'(guard_out), 1);
    check("R7 early low in dropout", int'(early_flag), 0);
    tone(4'hA, TP + 3, 0);
    check("R6 no second strobe", strobe_idx, 0);
    check("R6 code unchanged", int'(code_out), 5);
    gap(TA + 3);

    // R8: split bursts do not accumulate
    tone(4'h2, TP - 1, 0);
    gap(1);
    tone(4'h2, TP - 1, 0);
    gap(TA + 3);
    check("R8 split bursts rejected", int'(code_out), 5);

    // R5: a fresh digit after release, pulse one cycle wide
    tone(4'hF, TP + 2, 1);
    check("R5 strobe seen", strobe_idx, TP + 1);
    @(negedge clk);
    check("R5 strobe single", int'(digit_strobe), 0);
    gap(TA + 3);

    check("R5 all digits seen", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule